// File: doc/BRIEF.md
# Programmable Static Memory Strobe Sequencer

This block drives one bank of external static memory from a simple internal request port. Each accepted request is played out as a fixed-length access on a parallel bus: the address is held for the whole access, and chip-select, read-strobe, write-strobe and the byte-lane signals are each asserted for a window. Every window has its own start offset and its own width, counted in clock cycles from the first cycle of the access. A separately programmed access length ends the access whether or not the windows have closed, and cuts short any window that runs past it.

Reads and writes each have their own set of timing inputs. Three mode inputs set the rest of the behaviour. The first picks whether read data is captured when the read strobe deasserts or when chip-select deasserts. The second picks whether write data starts to be driven when the write strobe asserts or when chip-select asserts. The third picks whether the byte lanes act as byte selects beside a shared write strobe or act as one write strobe per byte. The data bus width is set by a parameter to 1, 2 or 4 bytes. All timing and mode inputs are sampled when a request is accepted, so software may reprogram them while an access is in flight.

Top module: `smc_strobe_seq`

## Requirements
- R1: `req_ready` is 1 exactly when no access is in progress, and a request is accepted only on a rising clock edge where `req_valid` and `req_ready` are both 1. A request offered while an access runs is ignored until the access has ended.
- R2: Cycle k=0 of an access is the first clock cycle after the acceptance edge. An access with length field L lasts max(L,1) cycles, and `rsp_done` is 1 for exactly one cycle, the final one (k = max(L,1)-1). `req_ready` is 1 again in the cycle after that.
- R3: `bus_cs_n` is 0 in the cycles k with S <= k < S+P and k within the access, where S and P are the chip-select start offset and width of the operation in use (read or write). At all other times it is 1.
- R4: With the same window rule and the strobe offset and width of the operation, `bus_rd_n` is 0 only during reads. `bus_we_n` is 0 only during writes, and only in byte-select mode. The two are never 0 together.
- R5: A read captures `bus_din` on the clock edge that ends the last cycle of the capture strobe's window. This is the read strobe when `m_capture_on_strobe`=1 and chip-select otherwise. `rsp_rdata` holds that value until the next capture. A read whose capture strobe never asserts leaves `rsp_rdata` unchanged.
- R6: During a write, `bus_doe` is 1 from the first cycle of the launch strobe's window through the final cycle of the access. The launch strobe is the write strobe when `m_launch_on_strobe`=1 and chip-select otherwise. `bus_doe` is 0 if the launch strobe never asserts. `bus_dout` carries the accepted write data.
- R7: In byte-select mode (`m_lane_per_byte_write`=0), bit i of `bus_lane_n` is 0 exactly when chip-select is asserted and bit i of the accepted byte enable is 1, for reads and writes alike.
- R8: In byte-write mode (`m_lane_per_byte_write`=1), bit i of `bus_lane_n` is 0 exactly during the write-strobe window of a write whose byte enable bit i is 1. During reads all lanes stay 1.
- R9: `bus_addr` holds the accepted address for the whole access. Changes to the timing inputs, mode inputs or request fields after acceptance do not alter the access in progress.
- R10: After reset all strobes and lanes are 1, `bus_doe` and `rsp_done` are 0, `req_ready` is 1 and `rsp_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 8*BUS_BYTES | Write data |
| req_be | input | BUS_BYTES | Byte enables |
| rsp_done | output | 1 | One-cycle pulse in the final cycle of an access |
| rsp_rdata | output | 8*BUS_BYTES | Last captured read data |
| t_rd_cs_setup | input | 8 | Read chip-select start offset |
| t_rd_cs_width | input | 8 | Read chip-select width |
| t_rd_strb_setup | input | 8 | Read strobe start offset |
| t_rd_strb_width | input | 8 | Read strobe width |
| t_rd_len | input | 8 | Read access length (0 counts as 1) |
| t_wr_cs_setup | input | 8 | Write chip-select start offset |
| t_wr_cs_width | input | 8 | Write chip-select width |
| t_wr_strb_setup | input | 8 | Write strobe start offset |
| t_wr_strb_width | input | 8 | Write strobe width |
| t_wr_len | input | 8 | Write access length (0 counts as 1) |
| m_capture_on_strobe | input | 1 | Capture read data when the read strobe ends rather than chip-select |
| m_launch_on_strobe | input | 1 | Start driving write data with the write strobe rather than chip-select |
| m_lane_per_byte_write | input | 1 | Lanes act as per-byte write strobes rather than byte selects |
| bus_addr | output | ADDR_W | External address |
| bus_dout | output | 8*BUS_BYTES | External write data |
| bus_doe | output | 1 | Write data output enable |
| bus_din | input | 8*BUS_BYTES | External read data |
| bus_cs_n | output | 1 | Chip-select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Shared write strobe, active low |
| bus_lane_n | output | BUS_BYTES | Byte lanes, active low |

## Verification
The main function is driven from a table of access shapes. These cover reads whose strobe window sits inside chip-select, reads whose windows overlap and end at different times, and windows that run past the access length and must be cut. They also cover writes launched from either strobe, writes in per-byte-write mode, a zero length, and zero-width strobes. Comparing each cycle against a window model separates the read and write timing sets, the two capture edges and the two launch points. The truncated and zero-width cases show whether the windows are clipped correctly and whether a missing strobe suppresses capture and drive. Every access scrambles the timing, mode and request inputs right after acceptance, which shows whether anything is read live instead of latched. A directed test holds a second request during an access to check that it waits for idle.

// File: rtl/smc_seq_pkg.sv
package smc_seq_pkg;

  localparam int unsigned TCNT_W = 8;

  typedef logic [TCNT_W-1:0] tcnt_t;

  // Timing of one access, latched at acceptance
  typedef struct packed {
    tcnt_t cs_setup;
    tcnt_t cs_pulse;
    tcnt_t st_setup;
    tcnt_t st_pulse;
    tcnt_t last;      // index of final cycle
  } op_timing_t;

  // A length of zero is treated as a one-cycle access
  function automatic tcnt_t last_index(input tcnt_t len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

endpackage

// File: rtl/smc_strobe_window.sv
module smc_strobe_window
  import smc_seq_pkg::*;
(
  input  logic  en,
  input  tcnt_t cnt,
  input  tcnt_t setup,
  input  tcnt_t pulse,
  output logic  act
);

  logic [TCNT_W:0] ofs;

  always_comb begin
    ofs = {1'b0, cnt} - {1'b0, setup};
    act = en && (cnt >= setup) && (ofs < {1'b0, pulse});
  end

endmodule

// File: rtl/smc_lane_strobes.sv
module smc_lane_strobes #(
  parameter int unsigned LANES = 2
) (
  input  logic             cs_act,
  input  logic             st_act,
  input  logic             is_write,
  input  logic             per_byte_write,
  input  logic [LANES-1:0] be,
  output logic [LANES-1:0] lane_act
);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_act[i] = be[i] && (per_byte_write ? (is_write && st_act) : cs_act);
  end

endmodule

// File: rtl/smc_strobe_seq.sv
module smc_strobe_seq
  import smc_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic [8*BUS_BYTES-1:0] req_wdata,
  input  logic [BUS_BYTES-1:0]   req_be,
  output logic                   rsp_done,
  output logic [8*BUS_BYTES-1:0] rsp_rdata,
  input  logic [TCNT_W-1:0]      t_rd_cs_setup,
  input  logic [TCNT_W-1:0]      t_rd_cs_width,
  input  logic [TCNT_W-1:0]      t_rd_strb_setup,
  input  logic [TCNT_W-1:0]      t_rd_strb_width,
  input  logic [TCNT_W-1:0]      t_rd_len,
  input  logic [TCNT_W-1:0]      t_wr_cs_setup,
  input  logic [TCNT_W-1:0]      t_wr_cs_width,
  input  logic [TCNT_W-1:0]      t_wr_strb_setup,
  input  logic [TCNT_W-1:0]      t_wr_strb_width,
  input  logic [TCNT_W-1:0]      t_wr_len,
  input  logic                   m_capture_on_strobe,
  input  logic                   m_launch_on_strobe,
  input  logic                   m_lane_per_byte_write,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic [8*BUS_BYTES-1:0] bus_dout,
  output logic                   bus_doe,
  input  logic [8*BUS_BYTES-1:0] bus_din,
  output logic                   bus_cs_n,
  output logic                   bus_rd_n,
  output logic                   bus_we_n,
  output logic [BUS_BYTES-1:0]   bus_lane_n
);

  localparam int unsigned DATA_W = 8 * BUS_BYTES;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // Latched request and configuration
  logic [ADDR_W-1:0]    addr_q;
  logic [DATA_W-1:0]    wdata_q;
  logic [BUS_BYTES-1:0] be_q;
  logic                 wr_q, capm_q, launm_q, lanem_q;
  op_timing_t           tim_q, tim_sel, tim_n;

  // Sequencer state
  logic                 busy_q, busy_d;
  tcnt_t                cnt_q, cnt_d;
  logic                 accept;

  // Registered outputs
  logic                 cs_n_q, rd_n_q, we_n_q, doe_q, done_q;
  logic [BUS_BYTES-1:0] lane_n_q;
  logic [DATA_W-1:0]    rdata_q;

  // Next-state helpers
  logic                 wr_n, capm_n, launm_n, lanem_n;
  logic [BUS_BYTES-1:0] be_n;
  logic                 cs_act_d, st_act_d, rd_d, we_d, launch_d, doe_d, done_d;
  logic [BUS_BYTES-1:0] lane_act_d;
  logic                 cap_now, cap_nxt, capture;
  logic [DATA_W-1:0]    rdata_d;

  assign accept = req_valid && !busy_q;

  always_comb begin
    if (req_write) begin
      tim_sel.cs_setup = t_wr_cs_setup;
      tim_sel.cs_pulse = t_wr_cs_width;
      tim_sel.st_setup = t_wr_strb_setup;
      tim_sel.st_pulse = t_wr_strb_width;
      tim_sel.last     = last_index(t_wr_len);
    end else begin
      tim_sel.cs_setup = t_rd_cs_setup;
      tim_sel.cs_pulse = t_rd_cs_width;
      tim_sel.st_setup = t_rd_strb_setup;
      tim_sel.st_pulse = t_rd_strb_width;
      tim_sel.last     = last_index(t_rd_len);
    end
  end

  always_comb begin
    tim_n   = accept ? tim_sel               : tim_q;
    wr_n    = accept ? req_write             : wr_q;
    capm_n  = accept ? m_capture_on_strobe   : capm_q;
    launm_n = accept ? m_launch_on_strobe    : launm_q;
    lanem_n = accept ? m_lane_per_byte_write : lanem_q;
    be_n    = accept ? req_be                : be_q;
  end

  // Cycle counter
  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (cnt_q == tim_q.last) begin
        busy_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  // Strobe windows evaluated for the next cycle
  smc_strobe_window u_cs_win (
    .en    (busy_d),
    .cnt   (cnt_d),
    .setup (tim_n.cs_setup),
    .pulse (tim_n.cs_pulse),
    .act   (cs_act_d)
  );

  smc_strobe_window u_st_win (
    .en    (busy_d),
    .cnt   (cnt_d),
    .setup (tim_n.st_setup),
    .pulse (tim_n.st_pulse),
    .act   (st_act_d)
  );

  smc_lane_strobes #(.LANES(BUS_BYTES)) u_lanes (
    .cs_act         (cs_act_d),
    .st_act         (st_act_d),
    .is_write       (wr_n),
    .per_byte_write (lanem_n),
    .be             (be_n),
    .lane_act       (lane_act_d)
  );

  always_comb begin
    rd_d     = st_act_d && !wr_n;
    we_d     = st_act_d && wr_n && !lanem_n;
    launch_d = launm_n ? st_act_d : cs_act_d;
    doe_d    = busy_d && wr_n && ((busy_q && doe_q) || launch_d);
    done_d   = busy_d && (cnt_d == tim_n.last);
    // Capture on the edge where the chosen strobe goes from asserted to released
    cap_now  = capm_q ? !rd_n_q : !cs_n_q;
    cap_nxt  = capm_n ? rd_d : cs_act_d;
    capture  = busy_q && !wr_q && cap_now && !cap_nxt;
    rdata_d  = capture ? bus_din : rdata_q;
  end

  // Payload registers, enabled on acceptance
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      wr_q    <= 1'b0;
      capm_q  <= 1'b0;
      launm_q <= 1'b0;
      lanem_q <= 1'b0;
      tim_q   <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
      wr_q    <= req_write;
      capm_q  <= m_capture_on_strobe;
      launm_q <= m_launch_on_strobe;
      lanem_q <= m_lane_per_byte_write;
      tim_q   <= tim_sel;
    end
  end

  // Control and output registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      busy_q   <= 1'b0;
      cnt_q    <= '0;
      cs_n_q   <= 1'b1;
      rd_n_q   <= 1'b1;
      we_n_q   <= 1'b1;
      lane_n_q <= '1;
      doe_q    <= 1'b0;
      done_q   <= 1'b0;
      rdata_q  <= '0;
    end else begin
      busy_q   <= busy_d;
      cnt_q    <= cnt_d;
      cs_n_q   <= !cs_act_d;
      rd_n_q   <= !rd_d;
      we_n_q   <= !we_d;
      lane_n_q <= ~lane_act_d;
      doe_q    <= doe_d;
      done_q   <= done_d;
      rdata_q  <= rdata_d;
    end
  end

  assign req_ready  = !busy_q;
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign bus_addr   = addr_q;
  assign bus_dout   = wdata_q;
  assign bus_doe    = doe_q;
  assign bus_cs_n   = cs_n_q;
  assign bus_rd_n   = rd_n_q;
  assign bus_we_n   = we_n_q;
  assign bus_lane_n = lane_n_q;

  // Checks next to the sequencing logic
  assert_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && $past(busy_q)) |-> $stable(bus_addr));

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |=> !rsp_done);

  assert_done_ends_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |=> req_ready);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_q |-> (bus_cs_n && bus_rd_n && bus_we_n && (&bus_lane_n) && !bus_doe));

  assert_no_rd_we_overlap_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(!bus_rd_n && !bus_we_n));

  assert_doe_on_write_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    bus_doe |-> (busy_q && wr_q));

  assert_doe_holds_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (bus_doe && !rsp_done) |=> bus_doe);

endmodule

// File: tb/smc_strobe_seq_test.sv
`timescale 1ns/1ps
module smc_strobe_seq_test;

  localparam int AW = 16;
  localparam int NB = 2;
  localparam int DW = 8 * NB;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [NB-1:0] req_be;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [7:0]    rcs_s, rcs_p, rst_s, rst_p, rlen, wcs_s, wcs_p, wst_s, wst_p, wlen;
  logic          capm, launm, lanem;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_dout, bus_din;
  logic          bus_doe, bus_cs_n, bus_rd_n, bus_we_n;
  logic [NB-1:0] bus_lane_n;

  always #5 clk = ~clk;

  smc_strobe_seq #(.ADDR_W(AW), .BUS_BYTES(NB)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .t_rd_cs_setup(rcs_s), .t_rd_cs_width(rcs_p), .t_rd_strb_setup(rst_s),
    .t_rd_strb_width(rst_p), .t_rd_len(rlen),
    .t_wr_cs_setup(wcs_s), .t_wr_cs_width(wcs_p), .t_wr_strb_setup(wst_s),
    .t_wr_strb_width(wst_p), .t_wr_len(wlen),
    .m_capture_on_strobe(capm), .m_launch_on_strobe(launm),
    .m_lane_per_byte_write(lanem),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_din(bus_din),
    .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n),
    .bus_lane_n(bus_lane_n)
  );

  typedef struct packed {
    logic       wr;
    logic [7:0] cs_s, cs_p, st_s, st_p, len;
    logic       cap, launch, lanem;
    logic [1:0] be;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'd0, 8'd6,  8'd1, 8'd4,  8'd7, 1'b1, 1'b0, 1'b0, 2'b11},
    '{1'b0, 8'd1, 8'd3,  8'd2, 8'd5,  8'd8, 1'b0, 1'b0, 1'b0, 2'b11},
    '{1'b0, 8'd0, 8'd20, 8'd3, 8'd20, 8'd6, 1'b1, 1'b0, 1'b0, 2'b01},
    '{1'b1, 8'd0, 8'd6,  8'd2, 8'd2,  8'd7, 1'b0, 1'b1, 1'b0, 2'b01},
    '{1'b1, 8'd1, 8'd4,  8'd2, 8'd2,  8'd6, 1'b0, 1'b0, 1'b0, 2'b10},
    '{1'b1, 8'd0, 8'd5,  8'd1, 8'd3,  8'd5, 1'b0, 1'b1, 1'b1, 2'b10},
    '{1'b0, 8'd0, 8'd1,  8'd0, 8'd1,  8'd0, 1'b1, 1'b0, 1'b0, 2'b11},
    '{1'b1, 8'd0, 8'd3,  8'd1, 8'd0,  8'd4, 1'b0, 1'b1, 1'b0, 2'b11},
    '{1'b0, 8'd0, 8'd4,  8'd1, 8'd0,  8'd5, 1'b1, 1'b0, 1'b0, 2'b11},
    '{1'b0, 8'd2, 8'd3,  8'd0, 8'd1,  8'd6, 1'b1, 1'b0, 1'b1, 2'b11}
  };

  int tests = 0;
  int fails = 0;
  logic [DW-1:0] exp_rdata;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit inwin(input int k, input int s, input int p);
    return (k >= s) && (k < s + p);
  endfunction

  task automatic set_cfg(input vec_t v);
    rcs_s = v.wr ? 8'd9 : v.cs_s;  rcs_p = v.wr ? 8'd9 : v.cs_p;
    rst_s = v.wr ? 8'd9 : v.st_s;  rst_p = v.wr ? 8'd9 : v.st_p;
    rlen  = v.wr ? 8'd9 : v.len;
    wcs_s = v.wr ? v.cs_s : 8'd9;  wcs_p = v.wr ? v.cs_p : 8'd9;
    wst_s = v.wr ? v.st_s : 8'd9;  wst_p = v.wr ? v.st_p : 8'd9;
    wlen  = v.wr ? v.len : 8'd9;
    capm = v.cap; launm = v.launch; lanem = v.lanem;
  endtask

  task automatic scramble();
    rcs_s = 8'd2; rcs_p = 8'd2; rst_s = 8'd2; rst_p = 8'd2; rlen = 8'd2;
    wcs_s = 8'd2; wcs_p = 8'd2; wst_s = 8'd2; wst_p = 8'd2; wlen = 8'd2;
    capm = ~capm; launm = ~launm; lanem = ~lanem;
    req_write = ~req_write; req_be = ~req_be;
    req_addr = ~req_addr; req_wdata = ~req_wdata;
  endtask

  task automatic run_vec(input int idx, input vec_t v);
    int last, s_cap_s, s_cap_p, l_s, l_p, first_l, cap_k;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    last = (v.len == 0) ? 0 : int'(v.len) - 1;
    s_cap_s = v.cap ? int'(v.st_s) : int'(v.cs_s);
    s_cap_p = v.cap ? int'(v.st_p) : int'(v.cs_p);
    l_s = v.launch ? int'(v.st_s) : int'(v.cs_s);
    l_p = v.launch ? int'(v.st_p) : int'(v.cs_p);
    first_l = -1;
    cap_k = -1;
    for (int k = 0; k <= last; k++) begin
      if (first_l < 0 && inwin(k, l_s, l_p)) first_l = k;
      if (inwin(k, s_cap_s, s_cap_p)) cap_k = k;
    end
    a = AW'(16'h1000 + idx * 16'h0111);
    d = DW'(16'hC0DE ^ (idx * 16'h0101));
    @(negedge clk);
    set_cfg(v);
    req_write = v.wr; req_be = v.be; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    scramble();
    for (int k = 0; k <= last; k++) begin
      logic cs_e, st_e, rd_ne, we_ne, doe_e;
      logic [NB-1:0] lane_ne;
      cs_e  = inwin(k, int'(v.cs_s), int'(v.cs_p));
      st_e  = inwin(k, int'(v.st_s), int'(v.st_p));
      rd_ne = !(!v.wr && st_e);
      we_ne = !(v.wr && !v.lanem && st_e);
      for (int i = 0; i < NB; i++)
        lane_ne[i] = !(v.be[i] && (v.lanem ? (v.wr && st_e) : cs_e));
      doe_e = v.wr && (first_l >= 0) && (k >= first_l);
      chk(bus_cs_n == !cs_e, $sformatf("R3 cs_n vec%0d k%0d", idx, k), 32'(bus_cs_n), 32'(!cs_e));
      chk({bus_rd_n, bus_we_n} == {rd_ne, we_ne}, $sformatf("R4 rd_n/we_n vec%0d k%0d", idx, k),
          32'({bus_rd_n, bus_we_n}), 32'({rd_ne, we_ne}));
      chk(bus_lane_n == lane_ne, $sformatf("%s lanes vec%0d k%0d", v.lanem ? "R8" : "R7", idx, k),
          32'(bus_lane_n), 32'(lane_ne));
      chk(bus_doe == doe_e, $sformatf("R6 doe vec%0d k%0d", idx, k), 32'(bus_doe), 32'(doe_e));
      if (doe_e)
        chk(bus_dout == d, $sformatf("R6 dout vec%0d k%0d", idx, k), 32'(bus_dout), 32'(d));
      chk(rsp_done == (k == last), $sformatf("R2 done vec%0d k%0d", idx, k), 32'(rsp_done), 32'(k == last));
      chk(req_ready == 1'b0, $sformatf("R1 ready busy vec%0d k%0d", idx, k), 32'(req_ready), 32'h0);
      chk(bus_addr == a, $sformatf("R9 addr vec%0d k%0d", idx, k), 32'(bus_addr), 32'(a));
      bus_din = DW'(16'h5A00 + idx * 16 + k);
      if (!v.wr && k == cap_k) exp_rdata = bus_din;
      @(negedge clk);
    end
    chk(req_ready == 1'b1, $sformatf("R2 ready after vec%0d", idx), 32'(req_ready), 32'h1);
    chk(rsp_done == 1'b0, $sformatf("R2 done after vec%0d", idx), 32'(rsp_done), 32'h0);
    chk(rsp_rdata == exp_rdata, $sformatf("R5 rdata vec%0d", idx), 32'(rsp_rdata), 32'(exp_rdata));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    bus_din = '0;
    set_cfg(VECS[0]);
    exp_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: reset state
    chk(bus_cs_n && bus_rd_n && bus_we_n, "R10 strobes after reset",
        32'({bus_cs_n, bus_rd_n, bus_we_n}), 32'h7);
    chk(bus_lane_n == '1, "R10 lanes after reset", 32'(bus_lane_n), 32'h3);
    chk(!bus_doe && !rsp_done, "R10 doe/done after reset", 32'({bus_doe, rsp_done}), 32'h0);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_rdata == '0, "R10 rdata after reset", 32'(rsp_rdata), 32'h0);

    // Table of access shapes; R9 latching is exercised by scramble() in each
    for (int n = 0; n < NV; n++) run_vec(n, VECS[n]);

    // R1: a request held during an access waits for idle
    @(negedge clk);
    set_cfg(VECS[0]);
    rlen = 8'd4;
    req_write = 1'b0; req_be = 2'b11; req_addr = 16'hAAAA; req_valid = 1'b1;
    @(negedge clk);
    req_addr = 16'h5555;
    for (int k = 0; k < 4; k++) begin
      chk(req_ready == 1'b0, $sformatf("R1 held ready k%0d", k), 32'(req_ready), 32'h0);
      chk(bus_addr == 16'hAAAA, $sformatf("R1 held addr k%0d", k), 32'(bus_addr), 32'hAAAA);
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R1 idle cycle ready", 32'(req_ready), 32'h1);
    chk(bus_addr == 16'hAAAA, "R1 idle cycle addr", 32'(bus_addr), 32'hAAAA);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1 second request taken", 32'(req_ready), 32'h0);
    chk(bus_addr == 16'h5555, "R1 second request addr", 32'(bus_addr), 32'h5555);
    repeat (6) @(negedge clk);
    chk(req_ready == 1'b1, "R2 ready after held request", 32'(req_ready), 32'h1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule